// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by reading two entries of an in-memory page table. A requester presents a virtual address and the current table root. The walker fetches the top-level entry, then the second-level (leaf) entry, and reports the physical address together with the raw leaf entry. If either entry is marked not valid, it reports a page fault instead.

Memory is reached through a read port with one request in flight at a time. A request is offered with a valid/ready handshake and held steady until it is taken. The answer comes back on a response strobe some cycles later. The virtual address is split 10/10/12: the upper ten bits index the top-level table, the next ten bits index the second-level table, and the low twelve bits are the offset within a 4 KB page.

Each table entry is 32 bits. The frame number sits in bits 31..12. The flags are valid (bit 0), writable (bit 1), cacheable (bit 2), dirty (bit 3) and referenced (bit 4).

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `done_o` and `mem_req_valid_o` are 0.
- R2: The first memory read of a walk targets `root + 4 * vaddr[31:22]`, where `root` is the value sampled at acceptance.
- R3: The second memory read targets `(top_entry[31:12] << 12) + 4 * vaddr[21:12]`.
- R4: On success, `paddr_o = {leaf[31:12], vaddr[11:0]}` and `leaf_o` equals the leaf entry. For example, vaddr 0x01005A6F with leaf frame 0xE gives 0x0000EA6F.
- R5: If bit 0 of the top-level entry is 0, the walk ends with `fault_o = 1`. No second read is issued, and `paddr_o` and `leaf_o` are 0.
- R6: If bit 0 of the leaf entry is 0, the walk ends with `fault_o = 1`, and `paddr_o` and `leaf_o` are 0.
- R7: `done_o` is high for exactly one cycle per walk. `paddr_o`, `leaf_o` and `fault_o` then hold until the next request is accepted.
- R8: A request is taken only while `req_ready_o` is 1, which happens only when idle. `req_valid_i` during a walk is ignored and starts no read.
- R9: `pt_root_i` is sampled at acceptance, so a change to it during a walk does not alter that walk.
- R10: A memory request holds its valid and address until `mem_req_ready_i` takes it. No new request is issued before the response to the previous one arrives.
- R11: Entry bits 1..4 (writable, cacheable, dirty, referenced) do not steer the walk, and they are returned unchanged in `leaf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker idle, request will be taken |
| req_vaddr_i | input | 32 | Virtual address to translate |
| pt_root_i | input | 32 | Byte address of the top-level table |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended in a page fault |
| paddr_o | output | 32 | Translated physical address |
| leaf_o | output | 32 | Leaf entry as read |

## Verification
The walk is swept over all 1024 top-level indices. Second-level indices, offsets and roots vary arithmetically, and the table contents are a computed function of the entry address. Each index therefore checks R2 and R3 separately, distinguishing top-index from second-index address errors. The computed valid pattern mixes top-level faults, leaf faults and successes, which separates R5 from R6. The memory alternates between instant acceptance and random back-pressure with response latencies of one to four cycles, which exposes handshake and hold faults. Some walks also toggle the root and pulse stray requests mid-walk to test R8 and R9. One fixed table reproduces the worked 0xEA6F example.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD_L1 = 2'd1,
    ST_RD_L2 = 2'd2,
    ST_DONE = 2'd3
  } ptw_state_e;

  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned NUM_LEVELS    = 2;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [IDX_W-1:0]  idx_top_o,
  output logic [IDX_W-1:0]  idx_leaf_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int unsigned LEAF_LSB = OFF_W;
  localparam int unsigned TOP_LSB  = OFF_W + IDX_W;

  assign off_o      = vaddr_i[OFF_W-1:0];
  assign idx_leaf_o = vaddr_i[LEAF_LSB +: IDX_W];
  assign idx_top_o  = vaddr_i[TOP_LSB +: IDX_W];
endmodule

// File: rtl/ptw_ent_addr.sv
module ptw_ent_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned PTE_W  = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SHIFT = $clog2(PTE_W / 8);
  localparam int unsigned PAD   = ADDR_W - IDX_W - SHIFT;

  logic [ADDR_W-1:0] scaled;

  assign scaled = {{PAD{1'b0}}, idx_i, {SHIFT{1'b0}}};
  assign addr_o = base_i + scaled;
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  input  logic pte_valid_i,
  output logic req_ready_o,
  output logic mem_req_valid_o,
  output logic level_o,
  output logic accept_o,
  output logic take_top_o,
  output logic take_leaf_o,
  output logic done_o
);
  ptw_state_e state_q, state_d;
  logic issued_q, issued_d;
  logic reading, rsp_take;

  assign reading         = (state_q == ST_RD_L1) || (state_q == ST_RD_L2);
  assign req_ready_o     = (state_q == ST_IDLE);
  assign accept_o        = req_ready_o && req_valid_i;
  assign mem_req_valid_o = reading && !issued_q;
  assign rsp_take        = reading && issued_q && mem_rsp_valid_i;
  assign take_top_o      = rsp_take && (state_q == ST_RD_L1);
  assign take_leaf_o     = rsp_take && (state_q == ST_RD_L2);
  assign level_o         = (state_q == ST_RD_L2);
  assign done_o          = (state_q == ST_DONE);

  always_comb begin
    state_d  = state_q;
    issued_d = issued_q;
    if (mem_req_valid_o && mem_req_ready_i) issued_d = 1'b1;
    if (rsp_take) issued_d = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_RD_L1;
      ST_RD_L1: if (rsp_take) state_d = pte_valid_i ? ST_RD_L2 : ST_DONE;
      ST_RD_L2: if (rsp_take) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
    end
  end

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o);
  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);
  a_r5_top_fault_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_top_o && !pte_valid_i |=> done_o && !mem_req_valid_o);
  a_r8_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PTE_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [ADDR_W-1:0] pt_root_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [PTE_W-1:0]  leaf_o
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  vaddr_q, root_q;
  logic [FRAME_W-1:0] top_frame_q;
  logic               fault_q;
  logic [ADDR_W-1:0]  paddr_q;
  logic [PTE_W-1:0]   leaf_q;

  logic accept, take_top, take_leaf, level;
  logic pte_valid;
  logic [FRAME_W-1:0] rsp_frame;
  logic [IDX_W-1:0]   idx_top, idx_leaf;
  logic [OFF_W-1:0]   off;

  logic [ADDR_W-1:0] lvl_base [NUM_LEVELS];
  logic [IDX_W-1:0]  lvl_idx  [NUM_LEVELS];
  logic [ADDR_W-1:0] lvl_addr [NUM_LEVELS];

  assign pte_valid = mem_rsp_data_i[PTE_VALID_BIT];
  assign rsp_frame = mem_rsp_data_i[PTE_W-1 -: FRAME_W];

  ptw_va_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .vaddr_i   (vaddr_q),
    .idx_top_o (idx_top),
    .idx_leaf_o(idx_leaf),
    .off_o     (off)
  );

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    if (g == 0) begin : g_top
      assign lvl_base[g] = root_q;
      assign lvl_idx[g]  = idx_top;
    end else begin : g_leaf
      assign lvl_base[g] = {top_frame_q, {OFF_W{1'b0}}};
      assign lvl_idx[g]  = idx_leaf;
    end
    ptw_ent_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_ea (
      .base_i(lvl_base[g]),
      .idx_i (lvl_idx[g]),
      .addr_o(lvl_addr[g])
    );
  end

  assign mem_req_addr_o = lvl_addr[level];

  ptw_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .pte_valid_i    (pte_valid),
    .req_ready_o    (req_ready_o),
    .mem_req_valid_o(mem_req_valid_o),
    .level_o        (level),
    .accept_o       (accept),
    .take_top_o     (take_top),
    .take_leaf_o    (take_leaf),
    .done_o         (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q     <= '0;
      root_q      <= '0;
      top_frame_q <= '0;
      fault_q     <= 1'b0;
      paddr_q     <= '0;
      leaf_q      <= '0;
    end else if (accept) begin
      vaddr_q <= req_vaddr_i;
      root_q  <= pt_root_i;
      fault_q <= 1'b0;
      paddr_q <= '0;
      leaf_q  <= '0;
    end else if (take_top) begin
      top_frame_q <= rsp_frame;
      if (!pte_valid) fault_q <= 1'b1;
    end else if (take_leaf) begin
      if (pte_valid) begin
        paddr_q <= {rsp_frame, off};
        leaf_q  <= mem_rsp_data_i;
      end else begin
        fault_q <= 1'b1;
      end
    end
  end

  assign fault_o = fault_q;
  assign paddr_o = paddr_q;
  assign leaf_o  = leaf_q;

  a_r10_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> $stable(mem_req_addr_o));
  a_r5_fault_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> paddr_o == '0 && leaf_o == '0);
  a_r4_frame_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> paddr_o[ADDR_W-1:OFF_W] == leaf_o[PTE_W-1 -: FRAME_W]
                           && leaf_o[PTE_VALID_BIT]);
  a_r9_root_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(root_q));
  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(paddr_o) || take_leaf || $past(take_leaf));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] vaddr = '0, root = '0;
  logic mreq_valid, mreq_ready = 1'b1;
  logic [31:0] mreq_addr;
  logic mrsp_valid = 1'b0;
  logic [31:0] mrsp_data = '0;
  logic done, fault;
  logic [31:0] paddr, leaf;

  int n_chk = 0, n_err = 0;
  int cycles = 0;
  int lat = 0;
  bit stall = 1'b0;
  bit ovr_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit pend = 1'b0;
  int pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  int total_req = 0;
  int overlap_err = 0;
  logic [31:0] addr_log [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(vaddr), .pt_root_i(root),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready),
    .mem_req_addr_o(mreq_addr),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data),
    .done_o(done), .fault_o(fault), .paddr_o(paddr), .leaf_o(leaf)
  );

  function automatic logic [31:0] ent(input logic [31:0] a);
    logic [19:0] fr;
    fr = (a[31:12] ^ {a[11:2], a[11:2]}) + 20'h3A5C5;
    return {fr, 7'd0, a[8:5], (a[4:2] != 3'd5)};
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (ovr_en && a == 32'h0000_2010) return 32'h0000_A001;
    if (ovr_en && a == 32'h0000_A014) return 32'h0000_E01F;
    return ent(a);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mreq_ready <= !stall || lfsr[0];
    mrsp_valid <= 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mrsp_valid <= 1'b1;
        mrsp_data <= mem_rd(pend_addr);
        pend <= 1'b0;
      end else pend_cnt <= pend_cnt - 1;
    end
    if (rst_n && mreq_valid && mreq_ready) begin
      if (pend || mrsp_valid) overlap_err <= overlap_err + 1;
      pend <= 1'b1;
      pend_cnt <= lat;
      pend_addr <= mreq_addr;
      addr_log[total_req % 4] <= mreq_addr;
      total_req <= total_req + 1;
    end
    if (cycles > 150000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] rt, input bit junk,
                      input bit use_fixed, input logic [31:0] fixed_pa);
    logic [31:0] e1, e2, a1, a2, exp_pa, exp_leaf;
    bit exp_fault;
    int nreq_exp, start, cyc;
    logic [31:0] pa_s, leaf_s;
    bit f_s;
    a1 = rt + {20'd0, va[31:22], 2'b00};
    e1 = mem_rd(a1);
    a2 = {e1[31:12], 12'd0} + {20'd0, va[21:12], 2'b00};
    e2 = mem_rd(a2);
    if (!e1[0]) begin
      exp_fault = 1; nreq_exp = 1; exp_pa = 0; exp_leaf = 0;
    end else if (!e2[0]) begin
      exp_fault = 1; nreq_exp = 2; exp_pa = 0; exp_leaf = 0;
    end else begin
      exp_fault = 0; nreq_exp = 2; exp_pa = {e2[31:12], va[11:0]}; exp_leaf = e2;
    end
    while (!req_ready) @(negedge clk);
    start = total_req;
    req_valid = 1'b1; vaddr = va; root = rt;
    @(negedge clk);
    root = ~rt;
    if (junk) vaddr = ~va; else req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin
      if (cyc == 1) req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(done, "R7 done seen", {31'd0, done}, 32'd1);
    chk(total_req - start == nreq_exp, "R5/R6/R8 read count", total_req - start, nreq_exp);
    chk(addr_log[start % 4] == a1, "R2/R9 top entry addr", addr_log[start % 4], a1);
    if (nreq_exp == 2)
      chk(addr_log[(start + 1) % 4] == a2, "R3 leaf entry addr", addr_log[(start + 1) % 4], a2);
    chk(fault == exp_fault, exp_fault ? (e1[0] ? "R6 leaf fault" : "R5 top fault") : "R4 no fault",
        {31'd0, fault}, {31'd0, exp_fault});
    chk(paddr == exp_pa, "R4 paddr", paddr, exp_pa);
    chk(leaf == exp_leaf, "R11 leaf flags intact", leaf, exp_leaf);
    if (use_fixed) chk(paddr == fixed_pa, "R4 worked example", paddr, fixed_pa);
    pa_s = paddr; leaf_s = leaf; f_s = fault;
    @(negedge clk);
    chk(!done, "R7 done one cycle", {31'd0, done}, 32'd0);
    chk(paddr == pa_s && leaf == leaf_s && fault == f_s, "R7 result hold", paddr, pa_s);
    chk(req_ready && !mreq_valid, "R8 idle after walk", {30'd0, req_ready, mreq_valid}, 32'd2);
  endtask

  initial begin
    #1;
    chk(req_ready && !done && !mreq_valid, "R1 reset state", {29'd0, req_ready, done, mreq_valid}, 32'd4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !mreq_valid, "R1 after reset", {29'd0, req_ready, done, mreq_valid}, 32'd4);
    ovr_en = 1'b1;
    walk(32'h0100_5A6F, 32'h0000_2000, 1'b0, 1'b1, 32'h0000_EA6F);
    ovr_en = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] va, rt;
      va = {i[9:0], 10'((i * 37 + 5) % 1024), 12'((i * 291) % 4096)};
      rt = {20'((i * 13 + 7) % 1048576), 12'd0};
      stall = i[0];
      lat = (i >> 1) % 4;
      walk(va, rt, (i % 3) == 0, 1'b0, 32'd0);
    end
    chk(overlap_err == 0, "R10 one outstanding", overlap_err, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule